// File: doc/BRIEF.md
# Burst-Aware Bus Read Sequencer

This block is the requesting side of a 32-bit external data bus. It takes one read request at a time and turns it into one or more data beats. Each beat carries a beat address, a two-bit transfer-size code, a burst flag, four byte-lane enables and a last-beat flag. A downstream bus stage acknowledges each beat.

A request carries a byte address, an access length and a line-fill flag. A line fill becomes a burst inside a four-word line. The burst starts at the addressed word, climbs toward the top word of the line and never wraps, so a fill that starts near the end of the line is shorter. An ordinary access becomes a single beat. Its size code and lane enables come from the low address bits and the requested length. A single access that would cross a word boundary is refused with a one-cycle error pulse and drives no beat.

Top module: `bus_xfer_seq`

## Requirements
- R1: While the reset is asserted, `req_ready`, `req_err`, `beat_valid`, `beat_burst`, `beat_last`, `beat_tsize` and `beat_lanes` are all zero. Once reset has been released (after the internal two-stage release), `req_ready` is 1.
- R2: A line fill whose word index is w (address bits [3:2]) produces 4-w beats. The beat addresses are the word-aligned request address, then that address plus 4, plus 8 and so on, in ascending order. The address never wraps past word 3.
- R3: On every beat of a line fill, `beat_burst` is 1, `beat_tsize` is 00 and `beat_lanes` is 4'b1111.
- R4: A single access gives exactly one beat, with `beat_burst` 0 and `beat_last` 1. Its `beat_tsize` equals the request length code. The length codes are 01 = 1 byte, 10 = 2 bytes, 11 = 3 bytes and 00 = 4 bytes. The beat address equals the request byte address.
- R5: For a single access, `beat_lanes[i]` (lane i, lane 0 being data bits 31:24) is 1 exactly when off <= i < off+n. Here off is address bits [1:0] and n is the byte count from the length code.
- R6: A single access with off+n > 4 raises `req_err` for exactly one cycle, in the cycle after acceptance, and produces no beat.
- R7: `beat_last` is 1 on the beat whose word index is 3 in a fill, and on the only beat of a single access. After an acknowledged last beat, `beat_valid` is 0 in the next cycle and `req_ready` returns to 1.
- R8: A request is accepted only while `req_ready` is 1. A `req_valid` pulse while beats are in progress produces no beat and no error.
- R9: While `beat_valid` is 1 and `beat_ack` is 0, every beat output holds its value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_fill | input | 1 | 1 = line fill burst, 0 = single access |
| req_len | input | 2 | Single access length code (01/10/11/00 = 1/2/3/4 bytes) |
| req_ready | output | 1 | Sequencer idle, request may be accepted |
| req_err | output | 1 | One-cycle pulse: misaligned request refused |
| beat_valid | output | 1 | Beat present on the beat outputs |
| beat_ack | input | 1 | Beat taken by the bus this cycle |
| beat_addr | output | 32 | Beat byte address |
| beat_tsize | output | 2 | Transfer-size code |
| beat_burst | output | 1 | Beat belongs to a line fill burst |
| beat_lanes | output | 4 | Byte-lane enables, bit i = lane i, lane 0 most significant |
| beat_last | output | 1 | Final beat of the transaction |

## Verification
Line fills are started at each of the four word positions. Their beat counts and final addresses show that the burst length follows the start word and that nothing wraps. Single accesses cover every length code at each offset where they fit, which separates errors in the lane run's start from errors in its length. Three length/offset pairs that cross the word boundary confirm the refusal. A request pushed in during a burst, together with an acknowledge that stalls on a fixed pattern, shows that extra requests are ignored and that beats are held while not taken.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  // transfer-size codes on the bus
  localparam logic [1:0] TSZ_WORD  = 2'b00;
  localparam logic [1:0] TSZ_BYTE  = 2'b01;
  localparam logic [1:0] TSZ_HALF  = 2'b10;
  localparam logic [1:0] TSZ_THREE = 2'b11;

  typedef struct packed {
    logic [1:0] tsize;
    logic       burst;
    logic [3:0] lanes;
  } beat_attr_t;

endpackage

// File: rtl/bus_rst_sync.sv
module bus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bus_lane_dec.sv
module bus_lane_dec
  import bus_seq_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] byte_off,
  input  logic [1:0]       len_code,
  input  logic             fill,
  output beat_attr_t       attr,
  output logic             misalign
);
  logic [OFF_W+1:0] nbytes;
  logic [OFF_W+1:0] end_pos;
  logic [LANES-1:0] lane_en;

  always_comb begin
    nbytes  = (len_code == TSZ_WORD) ? (OFF_W+2)'(LANES) : (OFF_W+2)'(len_code);
    end_pos = (OFF_W+2)'(byte_off) + nbytes;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = fill |
                        (((OFF_W+2)'(i) >= (OFF_W+2)'(byte_off)) &&
                         ((OFF_W+2)'(i) <  end_pos));
  end

  always_comb begin
    attr.burst = fill;
    attr.tsize = fill ? TSZ_WORD : len_code;
    attr.lanes = lane_en;
    misalign   = !fill && (end_pos > (OFF_W+2)'(LANES));
  end
endmodule

// File: rtl/bus_beat_ctrl.sv
module bus_beat_ctrl
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int WIDX_W    = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_fill,
  input  beat_attr_t        dec_attr,
  input  logic              dec_misalign,
  input  logic              beat_ack,
  output logic              req_ready,
  output logic              req_err,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output beat_attr_t        beat_attr,
  output logic              beat_last
);
  localparam logic [WIDX_W-1:0] TOP_WORD = WIDX_W'(LINE_WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  beat_attr_t        attr_q, attr_d;
  logic              err_q, err_d;
  logic              run_q;
  logic              accept, advance, at_top;

  assign at_top  = (addr_q[WIDX_W+1:2] == TOP_WORD);
  assign accept  = run_q && (state_q == SEQ_IDLE) && req_valid;
  assign advance = (state_q == SEQ_BUSY) && beat_ack;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    attr_d  = attr_q;
    err_d   = 1'b0;
    if (accept) begin
      if (dec_misalign) begin
        err_d = 1'b1;
      end else begin
        state_d = SEQ_BUSY;
        attr_d  = dec_attr;
        addr_d  = req_fill ? {req_addr[ADDR_W-1:2], 2'b00} : req_addr;
      end
    end else if (advance) begin
      if (beat_last) begin
        state_d = SEQ_IDLE;
        attr_d  = '0;
        addr_d  = '0;
      end else begin
        addr_d = addr_q + ADDR_W'(4);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      attr_q  <= '0;
      err_q   <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      run_q <= 1'b1;
      err_q <= err_d;
      if (accept || advance) begin
        state_q <= state_d;
        addr_q  <= addr_d;
        attr_q  <= attr_d;
      end
    end
  end

  assign req_ready  = run_q && (state_q == SEQ_IDLE);
  assign req_err    = err_q;
  assign beat_valid = (state_q == SEQ_BUSY);
  assign beat_addr  = addr_q;
  assign beat_attr  = attr_q;
  assign beat_last  = beat_valid && (!attr_q.burst || at_top);

  // R3
  burst_tsize_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid && beat_attr.burst |-> beat_attr.tsize == TSZ_WORD && beat_attr.lanes == '1);

  // R2
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid && beat_ack && !beat_last |=> beat_valid && beat_addr == $past(beat_addr) + ADDR_W'(4));

  // R7
  last_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid && beat_ack && beat_last |=> !beat_valid && req_ready);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid && !beat_ack |=> beat_valid && $stable(beat_addr) && $stable(beat_attr) && $stable(beat_last));

  // R6
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_err |-> !beat_valid && !$past(req_err));

  // R4
  single_last_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_valid && !beat_attr.burst |-> beat_last);

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> !beat_valid);
endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_fill,
  input  logic [1:0]        req_len,
  output logic              req_ready,
  output logic              req_err,
  output logic              beat_valid,
  input  logic              beat_ack,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [1:0]        beat_tsize,
  output logic              beat_burst,
  output logic [3:0]        beat_lanes,
  output logic              beat_last
);
  logic       rst_sync_n;
  beat_attr_t dec_attr, cur_attr;
  logic       dec_misalign;

  bus_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bus_lane_dec #(.LANES(4)) u_dec (
    .byte_off (req_addr[1:0]),
    .len_code (req_len),
    .fill     (req_fill),
    .attr     (dec_attr),
    .misalign (dec_misalign)
  );

  bus_beat_ctrl #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk          (clk),
    .rst_sync_n   (rst_sync_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_fill     (req_fill),
    .dec_attr     (dec_attr),
    .dec_misalign (dec_misalign),
    .beat_ack     (beat_ack),
    .req_ready    (req_ready),
    .req_err      (req_err),
    .beat_valid   (beat_valid),
    .beat_addr    (beat_addr),
    .beat_attr    (cur_attr),
    .beat_last    (beat_last)
  );

  assign beat_tsize = cur_attr.tsize;
  assign beat_burst = cur_attr.burst;
  assign beat_lanes = cur_attr.lanes;
endmodule

// File: tb/tb_bus_xfer_seq.sv
module tb_bus_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_fill = 1'b0;
  logic [1:0]  req_len = '0;
  logic        beat_ack = 1'b0;
  logic        req_ready, req_err, beat_valid, beat_burst, beat_last;
  logic [31:0] beat_addr;
  logic [1:0]  beat_tsize;
  logic [3:0]  beat_lanes;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit live = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  tsize;
    logic        burst;
    logic [3:0]  lanes;
    logic        last;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  bus_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_fill(req_fill), .req_len(req_len), .req_ready(req_ready), .req_err(req_err),
    .beat_valid(beat_valid), .beat_ack(beat_ack), .beat_addr(beat_addr),
    .beat_tsize(beat_tsize), .beat_burst(beat_burst), .beat_lanes(beat_lanes),
    .beat_last(beat_last)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // acknowledge pattern with stalls (R9)
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1 beat_ack = ((cyc % 3) != 1);
    end
  end

  // monitor: compares the visible beat with the queue head, pops on acknowledge
  always @(negedge clk) begin
    if (live && beat_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R8 unexpected beat", {32'h0, beat_addr}, 64'h0);
      end else begin
        check(beat_addr == q[0].addr, {q[0].tag, " addr"}, {32'h0, beat_addr}, {32'h0, q[0].addr});
        check({beat_tsize, beat_burst, beat_lanes, beat_last} ==
              {q[0].tsize, q[0].burst, q[0].lanes, q[0].last},
              {q[0].tag, " tsize/burst/lanes/last"},
              {55'h0, beat_tsize, beat_burst, beat_lanes, beat_last},
              {55'h0, q[0].tsize, q[0].burst, q[0].lanes, q[0].last});
        if (beat_ack) void'(q.pop_front());
      end
    end
  end

  task automatic send(input logic [31:0] a, input bit fill, input logic [1:0] len);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_fill = fill; req_len = len; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // driver: pushes the expected beats, then issues the request
  task automatic issue(input logic [31:0] a, input bit fill, input logic [1:0] len);
    int n, off;
    exp_t e;
    if (fill) begin
      for (int w = int'(a[3:2]); w < 4; w++) begin
        e.addr  = {a[31:4], 4'h0} + 32'(4 * w);
        e.tsize = 2'b00; e.burst = 1'b1; e.lanes = 4'b1111;
        e.last  = (w == 3);
        e.tag   = "R2 R3 R7 fill";
        q.push_back(e);
      end
      send(a, fill, len);
    end else begin
      n   = (len == 2'b00) ? 4 : int'(len);
      off = int'(a[1:0]);
      if (off + n > 4) begin
        send(a, fill, len);
        @(negedge clk);
        check(req_err == 1'b1 && beat_valid == 1'b0, "R6 error pulse", {62'h0, req_err, beat_valid}, 64'h2);
        @(negedge clk);
        check(req_err == 1'b0 && req_ready == 1'b1, "R6 pulse one cycle", {62'h0, req_err, req_ready}, 64'h1);
      end else begin
        e.addr = a; e.tsize = len; e.burst = 1'b0; e.last = 1'b1;
        for (int i = 0; i < 4; i++) e.lanes[i] = (i >= off) && (i < off + n);
        e.tag = "R4 R5 R7 single";
        q.push_back(e);
        send(a, fill, len);
      end
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0 || !req_ready) @(negedge clk);
    check(beat_valid == 1'b0, "R7 idle after last", {63'h0, beat_valid}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check({req_ready, req_err, beat_valid, beat_burst, beat_last, beat_tsize, beat_lanes} == '0,
          "R1 reset outputs",
          {51'h0, req_ready, req_err, beat_valid, beat_burst, beat_last, beat_tsize, beat_lanes}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", {63'h0, req_ready}, 64'h1);
    live = 1'b1;

    // fills at each word position (R2, R3, R7)
    for (int w = 0; w < 4; w++) begin
      issue(32'h1000_0040 + 32'(4 * w) + 32'(w), 1'b1, 2'b01);
      wait_idle();
    end

    // singles: every fitting length/offset pair (R4, R5)
    issue(32'h2000_0100, 1'b0, 2'b00); wait_idle();
    for (int o = 0; o < 4; o++) begin
      issue(32'h2000_0104 + 32'(o), 1'b0, 2'b01); wait_idle();
    end
    issue(32'h2000_0108, 1'b0, 2'b10); wait_idle();
    issue(32'h2000_010A, 1'b0, 2'b10); wait_idle();
    issue(32'h2000_0109, 1'b0, 2'b10); wait_idle();
    issue(32'h2000_0110, 1'b0, 2'b11); wait_idle();
    issue(32'h2000_0111, 1'b0, 2'b11); wait_idle();

    // boundary crossings refused (R6)
    issue(32'h3000_0003, 1'b0, 2'b10);
    issue(32'h3000_0001, 1'b0, 2'b00);
    issue(32'h3000_0002, 1'b0, 2'b11);

    // request during a burst is ignored (R8)
    issue(32'h4000_0020, 1'b1, 2'b00);
    @(negedge clk);
    check(req_ready == 1'b0, "R8 busy not ready", {63'h0, req_ready}, 64'h0);
    req_addr = 32'h5000_0003; req_fill = 1'b0; req_len = 2'b10; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check(req_err == 1'b0, "R8 no error from ignored request", {63'h0, req_err}, 64'h0);
    wait_idle();
    repeat (5) @(negedge clk);
    check(q.size() == 0 && beat_valid == 1'b0, "R8 no extra beat", {63'h0, beat_valid}, 64'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule